// File: doc/BRIEF.md
# Clock Trust State Evidence Tagger

This block watches the lock indication of a jitter-cleaning PLL and the valid flags of two redundant reference inputs, together with the current reference select. From these it keeps a three-valued clock trust state: locked, holdover or unlocked. Each change of that state becomes an alarm. Each alarm goes out in the same registered output stream as the telemetry samples, and every sample in that stream carries a trust label. A latency measurement taken in a degraded window is marked as such. A measurement that needs strict proof is accepted only when the clock is fully trusted.

The lock and valid inputs pass through per-input debouncers of programmable length. After the PLL re-locks, a programmable settle period keeps samples tagged as degraded. The block also keeps a saturating holdover timer and the timestamp at which holdover began. It counts unlock events and records how long the last unlock lasted. A free-running cycle counter provides all timestamps.

Top module: `clk_trust_tagger`

## Requirements
- R1: `trust_state_o` is 2'b00 locked, 2'b01 holdover, 2'b10 unlocked, and is unlocked after reset. One cycle after the filtered inputs, it follows this rule: filtered lock low gives unlocked; lock high with the selected reference (select 0 picks A, 1 picks B) filtered invalid gives holdover; otherwise locked.
- R2: Entry into holdover sets alarm bit 1 and loads `ho_start_o` with the timestamp of that cycle. It also clears `ho_timer_o`, which then rises by one on each cycle spent in holdover. The timestamp counts clock cycles since reset.
- R3: A change of `ref_sel_i` from its value in the previous cycle sets alarm bit 2. The word carries the new select and an event ID that rises by one on each change, starting at 1.
- R4: A fall of filtered lock sets alarm bit 0 and adds one to `unlock_cnt_o`. A rise sets alarm bit 3 and loads `relock_time_o` with the number of cycles that filtered lock was low.
- R5: A sample is tagged degraded if the state, before or after that cycle's update, is not locked, or if the settle period is running.
- R6: `ev_strict_ok_o` is high only for a sample marked strict that is not degraded.
- R7: One output word appears the cycle after any sample or alarm. It holds the sample, the alarm bits {relock, switch, holdover entry, unlock}, the timestamp, the select and the event ID together. Its data is zero when it carries no sample.
- R8: A filtered input takes a new raw value only after the raw value has differed for `deb_len_i`+1 consecutive cycles. A shorter glitch has no effect.
- R9: A rise of filtered lock loads a settle counter with `settle_len_i`. While that counter is nonzero, samples stay degraded even in the locked state.
- R10: `ho_timer_o` stops at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pll_lock_i | input | 1 | PLL lock indication |
| ref_a_ok_i | input | 1 | Reference A valid |
| ref_b_ok_i | input | 1 | Reference B valid |
| ref_sel_i | input | 1 | Selected reference, 0 = A, 1 = B |
| deb_len_i | input | DEB_W | Debounce length |
| settle_len_i | input | SET_W | Post-relock settle length |
| smp_valid_i | input | 1 | Telemetry sample present |
| smp_strict_i | input | 1 | Sample needs strict proof |
| smp_data_i | input | DATA_W | Sample value |
| ev_valid_o | output | 1 | Output word valid |
| ev_has_smp_o | output | 1 | Word carries a sample |
| ev_data_o | output | DATA_W | Sample value |
| ev_degraded_o | output | 1 | Sample taken in a degraded window |
| ev_strict_ok_o | output | 1 | Strict sample accepted |
| ev_alarm_o | output | 4 | {relock, switch, holdover entry, unlock} |
| ev_ts_o | output | TS_W | Timestamp |
| ev_ref_o | output | 1 | Reference select |
| ev_id_o | output | EID_W | Switch event ID |
| trust_state_o | output | 2 | Trust state |
| ho_timer_o | output | HO_W | Holdover timer |
| ho_start_o | output | TS_W | Timestamp of last holdover entry |
| unlock_cnt_o | output | CNT_W | Unlock count |
| relock_time_o | output | REL_W | Last unlock duration |

## Verification
A telemetry sample and a clock alarm can land in the same cycle. The bench provokes this by streaming samples on every cycle while it drops a reference, swaps the select, and pulls lock away and back. A sample that coincides with a transition must share its word with the alarm bits and must be tagged degraded, whichever side of the transition it falls on. Such a sample is never accepted as strict. The bench judges every word against a scoreboard that computes the expected word from the requirements. It also makes literal checks of relock time, glitch rejection and timer saturation.

// File: rtl/clk_trust_pkg.sv
package clk_trust_pkg;
  typedef enum logic [1:0] {
    ST_LOCKED   = 2'b00,
    ST_HOLDOVER = 2'b01,
    ST_UNLOCKED = 2'b10
  } trust_st_e;

  localparam int unsigned AL_UNLOCK = 0;
  localparam int unsigned AL_HOLD   = 1;
  localparam int unsigned AL_SWITCH = 2;
  localparam int unsigned AL_RELOCK = 3;
  localparam int unsigned AL_W      = 4;
endpackage

// File: rtl/trust_debounce.sv
module trust_debounce #(
  parameter int unsigned DEB_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raw_i,
  input  logic [DEB_W-1:0] len_i,
  output logic             filt_o
);
  logic [DEB_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_o <= 1'b0;
    end else if (raw_i == filt_o) begin
      cnt_q <= '0;
    end else if (cnt_q >= len_i) begin
      filt_o <= raw_i;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_glitch_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_i != filt_o && cnt_q < len_i) |=> (filt_o == $past(filt_o)));
endmodule

// File: rtl/trust_state_core.sv
module trust_state_core
  import clk_trust_pkg::*;
#(
  parameter int unsigned SET_W = 8,
  parameter int unsigned HO_W  = 12,
  parameter int unsigned TS_W  = 32,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned REL_W = 16,
  parameter int unsigned EID_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_f_i,
  input  logic             a_f_i,
  input  logic             b_f_i,
  input  logic             ref_sel_i,
  input  logic [SET_W-1:0] settle_len_i,
  input  logic [TS_W-1:0]  ts_i,
  output logic [AL_W-1:0]  alarm_o,
  output logic             degraded_o,
  output logic [EID_W-1:0] eid_nx_o,
  output logic [1:0]       state_o,
  output logic [HO_W-1:0]  ho_timer_o,
  output logic [TS_W-1:0]  ho_start_o,
  output logic [CNT_W-1:0] unlock_cnt_o,
  output logic [REL_W-1:0] relock_time_o
);
  localparam logic [HO_W-1:0]  HO_MAX  = {HO_W{1'b1}};
  localparam logic [REL_W-1:0] RUN_MAX = {REL_W{1'b1}};

  trust_st_e        state_q, state_nx;
  logic             lock_prev_q, sel_prev_q;
  logic [SET_W-1:0] settle_q, settle_nx;
  logic [HO_W-1:0]  ho_q;
  logic [REL_W-1:0] run_q;
  logic [EID_W-1:0] eid_q;
  logic             sel_ok, ev_unlock, ev_relock, ev_hold, ev_switch;

  always_comb begin
    sel_ok    = ref_sel_i ? b_f_i : a_f_i;
    if (!lock_f_i)    state_nx = ST_UNLOCKED;
    else if (!sel_ok) state_nx = ST_HOLDOVER;
    else              state_nx = ST_LOCKED;
    ev_unlock = lock_prev_q && !lock_f_i;
    ev_relock = !lock_prev_q && lock_f_i;
    ev_hold   = (state_nx == ST_HOLDOVER) && (state_q != ST_HOLDOVER);
    ev_switch = ref_sel_i != sel_prev_q;
    if (ev_relock)          settle_nx = settle_len_i;
    else if (settle_q != 0) settle_nx = settle_q - 1'b1;
    else                    settle_nx = '0;
    // conservative: degraded if either side of this cycle's update is untrusted
    degraded_o = (state_q != ST_LOCKED) || (settle_q != 0) ||
                 (state_nx != ST_LOCKED) || (settle_nx != 0);
    alarm_o = '0;
    alarm_o[AL_UNLOCK] = ev_unlock;
    alarm_o[AL_HOLD]   = ev_hold;
    alarm_o[AL_SWITCH] = ev_switch;
    alarm_o[AL_RELOCK] = ev_relock;
    eid_nx_o = ev_switch ? eid_q + 1'b1 : eid_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_UNLOCKED;
      lock_prev_q   <= 1'b0;
      sel_prev_q    <= 1'b0;
      settle_q      <= '0;
      ho_q          <= '0;
      ho_start_o    <= '0;
      unlock_cnt_o  <= '0;
      relock_time_o <= '0;
      run_q         <= '0;
      eid_q         <= '0;
    end else begin
      state_q     <= state_nx;
      lock_prev_q <= lock_f_i;
      sel_prev_q  <= ref_sel_i;
      settle_q    <= settle_nx;
      eid_q       <= eid_nx_o;
      if (ev_hold) begin
        ho_q       <= '0;
        ho_start_o <= ts_i;
      end else if (state_q == ST_HOLDOVER && ho_q != HO_MAX) begin
        ho_q <= ho_q + 1'b1;
      end
      if (ev_unlock) unlock_cnt_o <= unlock_cnt_o + 1'b1;
      if (ev_relock) relock_time_o <= run_q;
      if (lock_f_i)             run_q <= '0;
      else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
    end
  end

  assign state_o    = state_q;
  assign ho_timer_o = ho_q;

  assert_state_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != 2'b11);
  assert_hold_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_hold |=> (state_q == ST_HOLDOVER && ho_q == '0));
  assert_unlock_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_unlock |=> (unlock_cnt_o == $past(unlock_cnt_o) + 1'b1));
  assert_timer_saturate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLDOVER && state_nx == ST_HOLDOVER && ho_q == HO_MAX) |=> ho_q == HO_MAX);
  assert_settle_degraded_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settle_q != 0) |-> degraded_o);
endmodule

// File: rtl/trust_evidence_out.sv
module trust_evidence_out
  import clk_trust_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TS_W   = 32,
  parameter int unsigned EID_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic              smp_strict_i,
  input  logic [DATA_W-1:0] smp_data_i,
  input  logic [AL_W-1:0]   alarm_i,
  input  logic              degraded_i,
  input  logic [TS_W-1:0]   ts_i,
  input  logic              ref_sel_i,
  input  logic [EID_W-1:0]  eid_i,
  output logic              ev_valid_o,
  output logic              ev_has_smp_o,
  output logic [DATA_W-1:0] ev_data_o,
  output logic              ev_degraded_o,
  output logic              ev_strict_ok_o,
  output logic [AL_W-1:0]   ev_alarm_o,
  output logic [TS_W-1:0]   ev_ts_o,
  output logic              ev_ref_o,
  output logic [EID_W-1:0]  ev_id_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_valid_o     <= 1'b0;
      ev_has_smp_o   <= 1'b0;
      ev_data_o      <= '0;
      ev_degraded_o  <= 1'b0;
      ev_strict_ok_o <= 1'b0;
      ev_alarm_o     <= '0;
      ev_ts_o        <= '0;
      ev_ref_o       <= 1'b0;
      ev_id_o        <= '0;
    end else begin
      ev_valid_o     <= smp_valid_i || (alarm_i != '0);
      ev_has_smp_o   <= smp_valid_i;
      ev_data_o      <= smp_valid_i ? smp_data_i : '0;
      ev_degraded_o  <= smp_valid_i && degraded_i;
      ev_strict_ok_o <= smp_valid_i && smp_strict_i && !degraded_i;
      ev_alarm_o     <= alarm_i;
      ev_ts_o        <= ts_i;
      ev_ref_o       <= ref_sel_i;
      ev_id_o        <= eid_i;
    end
  end

  assert_strict_locked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_strict_ok_o |-> (ev_has_smp_o && !ev_degraded_o));
  assert_word_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_has_smp_o || ev_alarm_o != '0) |-> ev_valid_o);
endmodule

// File: rtl/clk_trust_tagger.sv
module clk_trust_tagger
  import clk_trust_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TS_W   = 32,
  parameter int unsigned DEB_W  = 8,
  parameter int unsigned SET_W  = 8,
  parameter int unsigned HO_W   = 12,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned REL_W  = 16,
  parameter int unsigned EID_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pll_lock_i,
  input  logic              ref_a_ok_i,
  input  logic              ref_b_ok_i,
  input  logic              ref_sel_i,
  input  logic [DEB_W-1:0]  deb_len_i,
  input  logic [SET_W-1:0]  settle_len_i,
  input  logic              smp_valid_i,
  input  logic              smp_strict_i,
  input  logic [DATA_W-1:0] smp_data_i,
  output logic              ev_valid_o,
  output logic              ev_has_smp_o,
  output logic [DATA_W-1:0] ev_data_o,
  output logic              ev_degraded_o,
  output logic              ev_strict_ok_o,
  output logic [3:0]        ev_alarm_o,
  output logic [TS_W-1:0]   ev_ts_o,
  output logic              ev_ref_o,
  output logic [EID_W-1:0]  ev_id_o,
  output logic [1:0]        trust_state_o,
  output logic [HO_W-1:0]   ho_timer_o,
  output logic [TS_W-1:0]   ho_start_o,
  output logic [CNT_W-1:0]  unlock_cnt_o,
  output logic [REL_W-1:0]  relock_time_o
);
  localparam int unsigned N_IN = 3;

  logic [N_IN-1:0]  raw, filt;
  logic [TS_W-1:0]  ts_q;
  logic [AL_W-1:0]  alarm;
  logic             degraded;
  logic [EID_W-1:0] eid_nx;

  assign raw = {ref_b_ok_i, ref_a_ok_i, pll_lock_i};

  for (genvar i = 0; i < N_IN; i++) begin : g_deb
    trust_debounce #(.DEB_W(DEB_W)) u_deb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw[i]),
      .len_i (deb_len_i),
      .filt_o(filt[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ts_q <= '0;
    else         ts_q <= ts_q + 1'b1;
  end

  trust_state_core #(
    .SET_W(SET_W), .HO_W(HO_W), .TS_W(TS_W),
    .CNT_W(CNT_W), .REL_W(REL_W), .EID_W(EID_W)
  ) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lock_f_i     (filt[0]),
    .a_f_i        (filt[1]),
    .b_f_i        (filt[2]),
    .ref_sel_i    (ref_sel_i),
    .settle_len_i (settle_len_i),
    .ts_i         (ts_q),
    .alarm_o      (alarm),
    .degraded_o   (degraded),
    .eid_nx_o     (eid_nx),
    .state_o      (trust_state_o),
    .ho_timer_o   (ho_timer_o),
    .ho_start_o   (ho_start_o),
    .unlock_cnt_o (unlock_cnt_o),
    .relock_time_o(relock_time_o)
  );

  trust_evidence_out #(.DATA_W(DATA_W), .TS_W(TS_W), .EID_W(EID_W)) u_out (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .smp_valid_i   (smp_valid_i),
    .smp_strict_i  (smp_strict_i),
    .smp_data_i    (smp_data_i),
    .alarm_i       (alarm),
    .degraded_i    (degraded),
    .ts_i          (ts_q),
    .ref_sel_i     (ref_sel_i),
    .eid_i         (eid_nx),
    .ev_valid_o    (ev_valid_o),
    .ev_has_smp_o  (ev_has_smp_o),
    .ev_data_o     (ev_data_o),
    .ev_degraded_o (ev_degraded_o),
    .ev_strict_ok_o(ev_strict_ok_o),
    .ev_alarm_o    (ev_alarm_o),
    .ev_ts_o       (ev_ts_o),
    .ev_ref_o      (ev_ref_o),
    .ev_id_o       (ev_id_o)
  );
endmodule

// File: tb/tb_clk_trust_tagger.sv
`timescale 1ns/1ps
module tb_clk_trust_tagger;
  logic clk = 0, rst_ni = 0;
  logic pll_lock = 0, ref_a = 0, ref_b = 0, ref_sel = 0;
  logic [7:0] deb_len = 8'd2, settle_len = 8'd3;
  logic smp_valid = 0, smp_strict = 0;
  logic [15:0] smp_data = 0;
  logic ev_valid, ev_has_smp, ev_degraded, ev_strict_ok, ev_ref;
  logic [15:0] ev_data;
  logic [3:0] ev_alarm;
  logic [31:0] ev_ts, ho_start;
  logic [7:0] ev_id, unlock_cnt;
  logic [1:0] trust_state;
  logic [11:0] ho_timer;
  logic [15:0] relock_time;

  always #5 clk = ~clk;

  clk_trust_tagger dut (
    .clk_i(clk), .rst_ni(rst_ni), .pll_lock_i(pll_lock), .ref_a_ok_i(ref_a),
    .ref_b_ok_i(ref_b), .ref_sel_i(ref_sel), .deb_len_i(deb_len),
    .settle_len_i(settle_len), .smp_valid_i(smp_valid), .smp_strict_i(smp_strict),
    .smp_data_i(smp_data), .ev_valid_o(ev_valid), .ev_has_smp_o(ev_has_smp),
    .ev_data_o(ev_data), .ev_degraded_o(ev_degraded), .ev_strict_ok_o(ev_strict_ok),
    .ev_alarm_o(ev_alarm), .ev_ts_o(ev_ts), .ev_ref_o(ev_ref), .ev_id_o(ev_id),
    .trust_state_o(trust_state), .ho_timer_o(ho_timer), .ho_start_o(ho_start),
    .unlock_cnt_o(unlock_cnt), .relock_time_o(relock_time)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  typedef struct packed {
    logic has; logic [15:0] data; logic deg; logic sok;
    logic [3:0] al; logic [31:0] ts; logic rf; logic [7:0] id;
  } word_t;
  word_t exp_q[$];

  // scoreboard reference, written from the requirements
  logic [2:0] m_f; int m_c[3];
  int m_st, m_se, m_ho, m_un, m_rel, m_run, m_id;
  logic m_lp, m_sp; longint m_ts, m_hs;
  bit exp_vld;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_f = 0; for (int i = 0; i < 3; i++) m_c[i] = 0;
      m_st = 2; m_se = 0; m_ho = 0; m_un = 0; m_rel = 0; m_run = 0; m_id = 0;
      m_lp = 0; m_sp = 0; m_ts = 0; m_hs = 0; exp_vld = 0; exp_q.delete();
    end else begin
      logic [2:0] rw; logic sok, eu, er, eh, es, dg; int nx, snx; word_t w;
      rw = {ref_b, ref_a, pll_lock};
      sok = ref_sel ? m_f[2] : m_f[1];
      nx = !m_f[0] ? 2 : (!sok ? 1 : 0);
      eu = m_lp && !m_f[0]; er = !m_lp && m_f[0];
      eh = (nx == 1) && (m_st != 1); es = ref_sel != m_sp;
      snx = er ? int'(settle_len) : (m_se != 0 ? m_se - 1 : 0);
      dg = (m_st != 0) || (m_se != 0) || (nx != 0) || (snx != 0);
      if (es) m_id = (m_id + 1) % 256;
      w.has = smp_valid; w.data = smp_valid ? smp_data : 16'h0;
      w.deg = smp_valid && dg; w.sok = smp_valid && smp_strict && !dg;
      w.al = {er, es, eh, eu}; w.ts = m_ts[31:0]; w.rf = ref_sel; w.id = m_id[7:0];
      exp_vld = smp_valid || (w.al != 0);
      if (exp_vld) exp_q.push_back(w);
      if (eh) begin m_ho = 0; m_hs = m_ts; end
      else if (m_st == 1 && m_ho != 4095) m_ho++;
      if (eu) m_un = (m_un + 1) % 256;
      if (er) m_rel = m_run;
      m_run = m_f[0] ? 0 : (m_run == 65535 ? 65535 : m_run + 1);
      m_st = nx; m_se = snx; m_lp = m_f[0]; m_sp = ref_sel; m_ts++;
      for (int i = 0; i < 3; i++) begin
        if (rw[i] == m_f[i]) m_c[i] = 0;
        else if (m_c[i] >= int'(deb_len)) begin m_f[i] = rw[i]; m_c[i] = 0; end
        else m_c[i]++;
      end
    end
  end

  // monitor: pops expected words away from the active edge
  bit mon_on = 0;
  always @(negedge clk) if (mon_on) begin
    chk(ev_valid == exp_vld, "R7 word valid", ev_valid, exp_vld);
    if (ev_valid && exp_q.size() != 0) begin
      word_t e; e = exp_q.pop_front();
      chk(ev_has_smp == e.has && ev_data == e.data, "R7 sample", ev_data, e.data);
      chk(ev_degraded == e.deg, "R5 degraded tag", ev_degraded, e.deg);
      chk(ev_strict_ok == e.sok, "R6 strict accept", ev_strict_ok, e.sok);
      chk(ev_alarm == e.al, "R4 alarm bits", ev_alarm, e.al);
      chk(ev_ts == e.ts, "R2 timestamp", ev_ts, e.ts);
      chk(ev_ref == e.rf && ev_id == e.id, "R3 ref/id", {ev_ref, ev_id}, {e.rf, e.id});
    end
    chk(trust_state == m_st[1:0], "R1 state", trust_state, m_st);
    chk(ho_timer == m_ho[11:0] && ho_start == m_hs[31:0], "R2 holdover", ho_timer, m_ho);
    chk(unlock_cnt == m_un[7:0] && relock_time == m_rel[15:0], "R4 stats", relock_time, m_rel);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic send(input logic strict, input logic [15:0] d);
    smp_valid = 1; smp_strict = strict; smp_data = d;
    cyc(1);
    smp_valid = 0; smp_strict = 0;
  endtask

  bit done = 0;
  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    // R1 reset state
    chk(trust_state == 2'b10, "R1 reset state", trust_state, 2);
    chk(ev_valid == 0 && unlock_cnt == 0 && ho_timer == 0, "R1 reset outputs", ev_valid, 0);
    rst_ni = 1; mon_on = 1;
    cyc(2);
    // acquire lock on reference A
    pll_lock = 1; ref_a = 1; ref_b = 1;
    cyc(6);
    chk(trust_state == 2'b00, "R1 locked", trust_state, 0);
    // R9 settle window: stream strict samples across it
    for (int i = 0; i < 6; i++) send(1, 16'h100 + 16'(i));
    // R5/R7 same-cycle: continuous samples while reference A drops
    smp_valid = 1; smp_strict = 1; smp_data = 16'hA5A5;
    ref_a = 0;
    cyc(8);
    chk(trust_state == 2'b01, "R2 holdover state", trust_state, 1);
    // R3 switch to B while samples continue
    ref_sel = 1;
    cyc(4);
    chk(trust_state == 2'b00, "R3 locked on B", trust_state, 0);
    ref_sel = 0; cyc(1); ref_sel = 1; cyc(6);
    smp_valid = 0; smp_strict = 0;
    // R8 glitch shorter than debounce
    pll_lock = 0; cyc(2); pll_lock = 1; cyc(6);
    chk(trust_state == 2'b00 && unlock_cnt == 0, "R8 glitch ignored", unlock_cnt, 0);
    // R4 unlock for 10 cycles with samples in flight
    smp_valid = 1; smp_data = 16'h0BEE;
    pll_lock = 0; cyc(10); pll_lock = 1; cyc(8);
    smp_valid = 0;
    chk(unlock_cnt == 1, "R4 unlock count", unlock_cnt, 1);
    chk(relock_time == 10, "R4 relock time", relock_time, 10);
    // R8 zero-length debounce
    deb_len = 0; settle_len = 0;
    ref_b = 0; cyc(2);
    chk(trust_state == 2'b01, "R8 immediate filter", trust_state, 1);
    // R10 holdover saturation
    cyc(4200);
    chk(ho_timer == 12'hFFF, "R10 timer saturates", ho_timer, 12'hFFF);
    send(1, 16'h7777);
    ref_b = 1; cyc(3);
    send(1, 16'h8888);
    cyc(3);
    done = 1; mon_on = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule